// File: doc/BRIEF.md
# Threshold alarm and extremes monitor

This block watches a stream of measurement results. Each result is 16 bits wide and carries a channel number. The block checks every result against an upper and a lower limit held for its channel. It raises one alarm bit per channel when the result leaves that window. The alarm stays held until a later in-window result on the same channel clears it. The block also keeps the highest and lowest value seen on each channel since reset.

One channel carries temperature, and it has its own over-temperature check. That check drives an over-temperature alarm. It also drives a shutdown request, but only when a specific enable code has been written into the over-temperature limit register. The shutdown request is off after reset.

Limits are written through a simple register write port. Limits, extremes and flags are read back through a read port with one cycle of latency. The address map is: upper limits at 0x00+ch, lower limits at 0x20+ch, maxima at 0x40+ch, minima at 0x60+ch, the alarm flags at 0x80, the over-temperature flags at 0x81, and the over-temperature limit register at 0xA0. Channel ch ranges from 0 to 15, and any other address reads zero.

Top module: `thresh_alarm_monitor`

## Requirements
- R1: After reset the block is in a known state. Every alarm, ot_alarm and shutdown_req read 0. Every upper limit reads 0xFFFF and every lower limit reads 0x0000. Every maximum reads 0x0000 and every minimum reads 0xFFFF. The over-temperature limit register reads 0xFFF0.
- R2: A valid sample strictly above its channel's upper limit sets alarm[ch] at the next clock edge. A sample equal to the upper limit does not set it. Comparisons are unsigned.
- R3: A valid sample strictly below its channel's lower limit sets alarm[ch] at the next clock edge. A sample equal to the lower limit does not set it.
- R4: An alarm bit holds while its channel produces out-of-window samples and while other channels are sampled. It clears at the edge after a sample on the same channel that lies inside the window, limits included.
- R5: For each channel, the register at 0x40+ch holds the largest sample seen since reset and the register at 0x60+ch holds the smallest. The first sample on a channel sets both.
- R6: Writes to 0x00+ch and 0x20+ch set the limits, and a write to 0xA0 sets the over-temperature register. Writes to the extremes and flag addresses have no effect. A read returns data on rd_data one clock after rd_en, and an unmapped address reads 0.
- R7: The register at 0x80 mirrors the alarm port. The register at 0x81 has ot_alarm in bit 0 and shutdown_req in bit 1.
- R8: The over-temperature threshold is {reg[15:4], 4'h0}, taken from the register at 0xA0. On channel 0, ot_alarm sets for a sample strictly above this threshold and clears for a sample at or below it.
- R9: shutdown_req rises together with an over-temperature set event, but only while the register at 0xA0 has 4'h5 in bits [3:0]. Any other nibble never raises it.
- R10: Once raised, shutdown_req stays at 1 until reset. Monitoring, extremes and readback keep working while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_valid | input | 1 | Sample present this cycle |
| meas_ch | input | 4 | Channel of the sample |
| meas_data | input | 16 | Sample value, unsigned |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 16 | Read data, valid one cycle after rd_en |
| alarm | output | 16 | Held alarm bit per channel |
| ot_alarm | output | 1 | Over-temperature alarm |
| shutdown_req | output | 1 | Sticky shutdown request |

## Verification
A vector table drives two channels with different windows. It lands samples exactly on each limit, one count beyond each limit, and inside the window. This separates strict from inclusive comparison on both sides and shows that an alarm on one channel survives samples on another. The same samples then fix the expected maxima and minima, including those of an untouched channel. Directed tests cover the over-temperature register with a wrong enable code and the right one, the stickiness of the shutdown request, the read-only regions, and a reset in the middle of the run.

// File: rtl/tam_pkg.sv
package tam_pkg;
  typedef enum logic [2:0] {
    RG_UPPER = 3'd0,
    RG_LOWER = 3'd1,
    RG_MAX   = 3'd2,
    RG_MIN   = 3'd3,
    RG_FLAG  = 3'd4,
    RG_OT    = 3'd5
  } tam_region_e;
endpackage

// File: rtl/tam_limit_bank.sv
module tam_limit_bank #(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_upper,
  input  logic              we_lower,
  input  logic [CH_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CH_W-1:0]   cur_ch,
  input  logic [CH_W-1:0]   rd_idx,
  output logic [DATA_W-1:0] cur_upper,
  output logic [DATA_W-1:0] cur_lower,
  output logic [DATA_W-1:0] rd_upper,
  output logic [DATA_W-1:0] rd_lower
);
  logic [DATA_W-1:0] upper_q [NUM_CH];
  logic [DATA_W-1:0] lower_q [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) begin
        upper_q[i] <= '1;
        lower_q[i] <= '0;
      end
    end else begin
      if (we_upper) upper_q[wr_idx] <= wr_data;
      if (we_lower) lower_q[wr_idx] <= wr_data;
    end
  end

  assign cur_upper = upper_q[cur_ch];
  assign cur_lower = lower_q[cur_ch];
  assign rd_upper  = upper_q[rd_idx];
  assign rd_lower  = lower_q[rd_idx];

  // R6
  upper_write_chk: assert property (@(posedge clk) disable iff (rst)
    we_upper |=> upper_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/tam_extremes.sv
module tam_extremes #(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              meas_valid,
  input  logic [CH_W-1:0]   meas_ch,
  input  logic [DATA_W-1:0] meas_data,
  input  logic [CH_W-1:0]   rd_idx,
  output logic [DATA_W-1:0] rd_max,
  output logic [DATA_W-1:0] rd_min
);
  logic [DATA_W-1:0] max_q [NUM_CH];
  logic [DATA_W-1:0] min_q [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) begin
        max_q[i] <= '0;
        min_q[i] <= '1;
      end
    end else if (meas_valid) begin
      if (meas_data > max_q[meas_ch]) max_q[meas_ch] <= meas_data;
      if (meas_data < min_q[meas_ch]) min_q[meas_ch] <= meas_data;
    end
  end

  assign rd_max = max_q[rd_idx];
  assign rd_min = min_q[rd_idx];

  // R5
  max_cover_chk: assert property (@(posedge clk) disable iff (rst)
    meas_valid |=> max_q[$past(meas_ch)] >= $past(meas_data));
  // R5
  min_cover_chk: assert property (@(posedge clk) disable iff (rst)
    meas_valid |=> min_q[$past(meas_ch)] <= $past(meas_data));
endmodule

// File: rtl/tam_ot_guard.sv
module tam_ot_guard #(
  parameter int NUM_CH          = 16,
  parameter int DATA_W          = 16,
  parameter int OT_CH           = 0,
  parameter logic [3:0] EN_CODE = 4'h5,
  localparam int CH_W           = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_ot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              meas_valid,
  input  logic [CH_W-1:0]   meas_ch,
  input  logic [DATA_W-1:0] meas_data,
  output logic [DATA_W-1:0] ot_reg,
  output logic              ot_alarm,
  output logic              shutdown_req
);
  localparam logic [DATA_W-1:0] OT_RST = {{(DATA_W-4){1'b1}}, 4'h0};

  logic [DATA_W-1:0] ot_q;
  logic [DATA_W-1:0] thr;
  logic              en_ok, hit, over;
  logic              ot_flag_q, sd_q;

  assign thr   = {ot_q[DATA_W-1:4], 4'h0};
  assign en_ok = (ot_q[3:0] == EN_CODE);
  assign hit   = meas_valid && (meas_ch == CH_W'(OT_CH));
  assign over  = meas_data > thr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ot_q      <= OT_RST;
      ot_flag_q <= 1'b0;
      sd_q      <= 1'b0;
    end else begin
      if (we_ot) ot_q <= wr_data;
      if (hit) begin
        ot_flag_q <= over;
        if (over && en_ok) sd_q <= 1'b1;
      end
    end
  end

  assign ot_reg       = ot_q;
  assign ot_alarm     = ot_flag_q;
  assign shutdown_req = sd_q;

  // R8
  ot_follow_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> ot_flag_q == ($past(meas_data) > $past(thr)));
  // R9
  sd_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!sd_q && !en_ok) |=> !sd_q);
  // R10
  sd_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    sd_q |=> sd_q);
endmodule

// File: rtl/thresh_alarm_monitor.sv
module thresh_alarm_monitor
  import tam_pkg::*;
#(
  parameter int NUM_CH             = 16,
  parameter int DATA_W             = 16,
  parameter int ADDR_W             = 8,
  parameter int OT_CH              = 0,
  parameter logic [3:0] OT_EN_CODE = 4'h5,
  localparam int CH_W              = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              meas_valid,
  input  logic [CH_W-1:0]   meas_ch,
  input  logic [DATA_W-1:0] meas_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CH-1:0] alarm,
  output logic              ot_alarm,
  output logic              shutdown_req
);
  tam_region_e       wr_rg, rd_rg;
  logic              wr_tab, rd_tab;
  logic [CH_W-1:0]   wr_idx, rd_idx;
  logic [DATA_W-1:0] cur_upper, cur_lower;
  logic [DATA_W-1:0] rd_upper, rd_lower, rd_max, rd_min, ot_reg;
  logic [DATA_W-1:0] rd_next, rd_q;
  logic [NUM_CH-1:0] alarm_q;
  logic              out_rng;

  assign wr_rg  = tam_region_e'(wr_addr[ADDR_W-1:ADDR_W-3]);
  assign rd_rg  = tam_region_e'(rd_addr[ADDR_W-1:ADDR_W-3]);
  assign wr_tab = (wr_addr[ADDR_W-4:CH_W] == '0);
  assign rd_tab = (rd_addr[ADDR_W-4:CH_W] == '0);
  assign wr_idx = wr_addr[CH_W-1:0];
  assign rd_idx = rd_addr[CH_W-1:0];

  tam_limit_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_limits (
    .clk(clk), .rst(rst),
    .we_upper(wr_en && wr_tab && wr_rg == RG_UPPER),
    .we_lower(wr_en && wr_tab && wr_rg == RG_LOWER),
    .wr_idx(wr_idx), .wr_data(wr_data),
    .cur_ch(meas_ch), .rd_idx(rd_idx),
    .cur_upper(cur_upper), .cur_lower(cur_lower),
    .rd_upper(rd_upper), .rd_lower(rd_lower)
  );

  tam_extremes #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_extremes (
    .clk(clk), .rst(rst),
    .meas_valid(meas_valid), .meas_ch(meas_ch), .meas_data(meas_data),
    .rd_idx(rd_idx), .rd_max(rd_max), .rd_min(rd_min)
  );

  tam_ot_guard #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .OT_CH(OT_CH),
                 .EN_CODE(OT_EN_CODE)) u_ot (
    .clk(clk), .rst(rst),
    .we_ot(wr_en && wr_rg == RG_OT && wr_addr[ADDR_W-4:0] == '0),
    .wr_data(wr_data),
    .meas_valid(meas_valid), .meas_ch(meas_ch), .meas_data(meas_data),
    .ot_reg(ot_reg), .ot_alarm(ot_alarm), .shutdown_req(shutdown_req)
  );

  assign out_rng = (meas_data > cur_upper) || (meas_data < cur_lower);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_alarm
    always_ff @(posedge clk) begin
      if (rst) alarm_q[c] <= 1'b0;
      else if (meas_valid && meas_ch == CH_W'(c)) alarm_q[c] <= out_rng;
    end
  end

  always_comb begin
    rd_next = '0;
    unique case (rd_rg)
      RG_UPPER: if (rd_tab) rd_next = rd_upper;
      RG_LOWER: if (rd_tab) rd_next = rd_lower;
      RG_MAX:   if (rd_tab) rd_next = rd_max;
      RG_MIN:   if (rd_tab) rd_next = rd_min;
      RG_FLAG: begin
        if (rd_addr[ADDR_W-4:0] == '0)
          rd_next = DATA_W'(alarm_q);
        else if (rd_addr[ADDR_W-4:0] == (ADDR_W-3)'(1))
          rd_next = DATA_W'({shutdown_req, ot_alarm});
      end
      RG_OT:    if (rd_addr[ADDR_W-4:0] == '0) rd_next = ot_reg;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_next;
  end

  assign rd_data = rd_q;
  assign alarm   = alarm_q;

  // R2
  alarm_set_chk: assert property (@(posedge clk) disable iff (rst)
    (meas_valid && out_rng) |=> alarm_q[$past(meas_ch)]);
  // R4
  alarm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (meas_valid && !out_rng) |=> !alarm_q[$past(meas_ch)]);
  // R4
  alarm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !meas_valid |=> $stable(alarm_q));
endmodule

// File: tb/tb_thresh_alarm_monitor.sv
module tb_thresh_alarm_monitor;
  logic        clk = 1'b0;
  logic        rst;
  logic        meas_valid;
  logic [3:0]  meas_ch;
  logic [15:0] meas_data;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic        rd_en;
  logic [7:0]  rd_addr;
  logic [15:0] rd_data;
  logic [15:0] alarm;
  logic        ot_alarm;
  logic        shutdown_req;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  thresh_alarm_monitor dut (
    .clk(clk), .rst(rst),
    .meas_valid(meas_valid), .meas_ch(meas_ch), .meas_data(meas_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .alarm(alarm), .ot_alarm(ot_alarm), .shutdown_req(shutdown_req)
  );

  // {ch[35:32], data[31:16], expected alarm[15:0]}
  // ch3 window 0x1000..0x8000, ch5 window 0x0080..0x0100
  localparam logic [35:0] VEC [10] = '{
    {4'd3, 16'h8000, 16'h0000},
    {4'd3, 16'h8001, 16'h0008},
    {4'd5, 16'h0090, 16'h0008},
    {4'd3, 16'h0FFF, 16'h0008},
    {4'd3, 16'h1000, 16'h0000},
    {4'd5, 16'h007F, 16'h0020},
    {4'd5, 16'h0101, 16'h0020},
    {4'd3, 16'h0000, 16'h0028},
    {4'd5, 16'h0100, 16'h0008},
    {4'd3, 16'h4000, 16'h0000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic smp(input logic [3:0] c, input logic [15:0] d);
    @(negedge clk); meas_valid = 1'b1; meas_ch = c; meas_data = d;
    @(negedge clk); meas_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rst = 1'b1; meas_valid = 1'b0; meas_ch = '0; meas_data = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_en = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 alarm", alarm, 16'h0000);
    chk("R1 ot/sd", {14'd0, shutdown_req, ot_alarm}, 16'h0000);
    rd(8'h07, v); chk("R1 upper", v, 16'hFFFF);
    rd(8'h27, v); chk("R1 lower", v, 16'h0000);
    rd(8'h47, v); chk("R1 max", v, 16'h0000);
    rd(8'h67, v); chk("R1 min", v, 16'hFFFF);
    rd(8'hA0, v); chk("R1 ot reg", v, 16'hFFF0);

    // R6 limit writes and readback
    wr(8'h03, 16'h8000); wr(8'h23, 16'h1000);
    wr(8'h05, 16'h0100); wr(8'h25, 16'h0080);
    rd(8'h03, v); chk("R6 upper3", v, 16'h8000);
    rd(8'h25, v); chk("R6 lower5", v, 16'h0080);
    rd(8'hC0, v); chk("R6 unmapped", v, 16'h0000);

    // R2 R3 R4 vector table
    for (int i = 0; i < 10; i++) begin
      smp(VEC[i][35:32], VEC[i][31:16]);
      chk($sformatf("R2/R3/R4 vec%0d", i), alarm, VEC[i][15:0]);
    end

    // R7 flag mirror: last state was 0, set ch3 again
    smp(4'd3, 16'hFFFF);
    rd(8'h80, v); chk("R7 flags", v, 16'h0008);

    // R5 extremes
    rd(8'h43, v); chk("R5 max3", v, 16'hFFFF);
    rd(8'h63, v); chk("R5 min3", v, 16'h0000);
    rd(8'h45, v); chk("R5 max5", v, 16'h0101);
    rd(8'h65, v); chk("R5 min5", v, 16'h007F);
    rd(8'h47, v); chk("R5 untouched max7", v, 16'h0000);

    // R6 read-only regions ignore writes
    wr(8'h45, 16'h1234); rd(8'h45, v); chk("R6 ro max", v, 16'h0101);
    wr(8'h80, 16'h0000); rd(8'h80, v); chk("R6 ro flags", v, 16'h0008);

    // R8 R9 wrong enable code
    wr(8'hA0, 16'h7006);
    smp(4'd0, 16'h7001);
    chk("R8 ot set", {15'd0, ot_alarm}, 16'h0001);
    chk("R9 no sd wrong code", {15'd0, shutdown_req}, 16'h0000);
    smp(4'd0, 16'h7000);
    chk("R8 ot clear at thr", {15'd0, ot_alarm}, 16'h0000);

    // R9 right code
    wr(8'hA0, 16'h7005);
    smp(4'd0, 16'h7000);
    chk("R9 no sd at thr", {15'd0, shutdown_req}, 16'h0000);
    smp(4'd0, 16'h7001);
    chk("R9 sd raised", {14'd0, shutdown_req, ot_alarm}, 16'h0003);

    // R10 sticky, data retained
    smp(4'd0, 16'h6000);
    chk("R10 sd sticky", {14'd0, shutdown_req, ot_alarm}, 16'h0002);
    rd(8'h81, v); chk("R7 ot flags", v, 16'h0002);
    rd(8'h40, v); chk("R10 max0 kept", v, 16'h7001);
    smp(4'd3, 16'h2000);
    chk("R10 monitoring continues", alarm, 16'h0000);

    // R1 reset clears shutdown
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 sd after reset", {14'd0, shutdown_req, ot_alarm}, 16'h0000);
    rd(8'h43, v); chk("R1 max3 after reset", v, 16'h0000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule